// File: doc/BRIEF.md
# Periodic Memory Scrub Sequencer

This block keeps soft errors from piling up in an error-corrected memory. A free-running timer raises a scrub request once per programmed number of clock cycles. When the request is taken, the block pulls the ready line to the user side low and raises a bus-select line, which tells the error-correcting codec to take its address and commands from the scrubber and not from the user port. The block then reads the codeword at the current scrub address through the codec, waits for the decoder, and writes the corrected and re-encoded word back to the same address. After the write completes it hands the bus back and moves the scrub address on to the next codeword.

A pass can clear random upsets, but symbols that are permanently broken stay broken, so a codeword the decoder calls uncorrectable is left untouched. Its address is logged and an error tally is raised. A scrub request never cuts into a user access that is already under way. It waits until the user side reports the access finished.

Top module: `scrub_ctrl`

## Requirements
- R1: From the cycle the read command is issued until the scrub operation ends, `usr_ready` is 0. It is 0 in every cycle where `scr_rd` or `scr_wr` is 1.
- R2: `codec_sel` is 1 exactly when `usr_ready` is 0. Otherwise it is 0.
- R3: Each operation starts with a single-cycle `scr_rd` pulse carrying the scrub address. No write is issued before `dec_done` has been seen for that read.
- R4: After `dec_done` with `dec_uncorr` = 0, a single-cycle `scr_wr` pulse follows in the next cycle. It carries the same address as the read.
- R5: `usr_ready` returns to 1 in the cycle after `wr_done` is 1. For an uncorrectable word, it returns to 1 in the cycle after `dec_done` is 1.
- R6: With `cfg_period` = P > 0, the timer makes one request every P cycles. While the bus is free and each operation is shorter than P, successive read pulses are exactly P cycles apart. With `cfg_period` = 0, no request is raised.
- R7: While `user_busy` is 1, no read is issued and `usr_ready` stays 1. If a request is pending, the read is issued in the cycle after the first cycle in which `user_busy` is 0.
- R8: `scr_addr` holds steady during an operation. After each operation, including a skipped write-back, it steps by one. It wraps from NUM_WORDS-1 to 0.
- R9: When `dec_uncorr` = 1 with `dec_done`, no write is issued. `err_count` rises by one and saturates at its maximum. `err_addr` takes the failing address.
- R10: After reset: `usr_ready` = 1, `codec_sel` = 0, `scr_rd` = `scr_wr` = 0, `scr_addr` = 0, `err_count` = 0, `err_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_period | input | PERIOD_W | Cycles between scrub requests; 0 stops scrubbing |
| user_busy | input | 1 | A user access is still in flight |
| usr_ready | output | 1 | User side may issue requests |
| codec_sel | output | 1 | Codec takes address and commands from the scrubber |
| scr_addr | output | ADDR_W | Codeword address being scrubbed |
| scr_rd | output | 1 | Read command pulse |
| scr_wr | output | 1 | Write-back command pulse |
| dec_done | input | 1 | Decoder finished the codeword |
| dec_uncorr | input | 1 | Decoded word is uncorrectable (valid with dec_done) |
| wr_done | input | 1 | Write-back finished in memory |
| err_count | output | ERR_W | Saturating count of uncorrectable words |
| err_addr | output | ADDR_W | Address of the last uncorrectable word |

## Verification
A sequencer stuck in the wrong state shows up at the ports within a single operation. The read address would not match the predicted walk, or a write pulse would appear with no clean decode before it. The ready line would also fail to come back on the cycle after the completion strobe. A drifting timer shows up as read-to-read spacing that differs from the programmed period, which can be seen on the second request. A wrong pending flag shows up as a read while the user side is busy. Error-log faults appear on the tally and address outputs as soon as an uncorrectable word has been handled.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE     = 3'd0,
        SQ_READ     = 3'd1,
        SQ_WAIT_DEC = 3'd2,
        SQ_WRITE    = 3'd3,
        SQ_WAIT_WR  = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       ready;
        logic       sel;
    } seq_regs_t;

endpackage

// File: rtl/scrub_timer.sv
module scrub_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic                clear,
    output logic                pending
);

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic                pend;
    } tmr_regs_t;

    tmr_regs_t r_q, r_d;
    logic      tick;

    always_comb begin
        r_d  = r_q;
        tick = 1'b0;
        if (period == '0) begin
            r_d.cnt = '0;
        end else if (r_q.cnt >= period - 1'b1) begin
            r_d.cnt = '0;
            tick    = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        // a tick in the same cycle as an accept starts a fresh request
        r_d.pend = tick | (r_q.pend & ~clear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pending = r_q.pend;

endmodule

// File: rtl/scrub_addr_gen.sv
module scrub_addr_gen #(
    parameter int ADDR_W    = 4,
    parameter int NUM_WORDS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_WORDS - 1);

    logic [ADDR_W-1:0] addr_q, addr_d, addr_inc;

    generate
        if (NUM_WORDS == (1 << ADDR_W)) begin : g_pow2
            assign addr_inc = addr_q + 1'b1;
        end else begin : g_cmp
            assign addr_inc = (addr_q == LAST) ? '0 : addr_q + 1'b1;
        end
    endgenerate

    always_comb begin
        addr_d = addr_q;
        if (step) addr_d = addr_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

endmodule

// File: rtl/scrub_err_log.sv
module scrub_err_log #(
    parameter int ADDR_W   = 4,
    parameter int ERR_W    = 8,
    parameter bit SATURATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ERR_W-1:0]  count,
    output logic [ADDR_W-1:0] last_addr
);

    typedef struct packed {
        logic [ERR_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
    } log_regs_t;

    log_regs_t         r_q, r_d;
    logic [ERR_W-1:0]  cnt_next;

    generate
        if (SATURATE) begin : g_sat
            assign cnt_next = (&r_q.cnt) ? r_q.cnt : r_q.cnt + 1'b1;
        end else begin : g_wrap
            assign cnt_next = r_q.cnt + 1'b1;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (hit) begin
            r_d.cnt  = cnt_next;
            r_d.addr = addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign count     = r_q.cnt;
    assign last_addr = r_q.addr;

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
    import scrub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic user_busy,
    input  logic dec_done,
    input  logic dec_uncorr,
    input  logic wr_done,
    output logic accept,
    output logic step,
    output logic err_hit,
    output logic ready,
    output logic sel,
    output logic rd,
    output logic wr
);

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        accept  = 1'b0;
        step    = 1'b0;
        err_hit = 1'b0;
        unique case (r_q.state)
            SQ_IDLE: begin
                if (pending && !user_busy) begin
                    accept    = 1'b1;
                    r_d.state = SQ_READ;
                end
            end
            SQ_READ: r_d.state = SQ_WAIT_DEC;
            SQ_WAIT_DEC: begin
                if (dec_done) begin
                    if (dec_uncorr) begin
                        err_hit   = 1'b1;
                        step      = 1'b1;
                        r_d.state = SQ_IDLE;
                    end else begin
                        r_d.state = SQ_WRITE;
                    end
                end
            end
            SQ_WRITE: r_d.state = SQ_WAIT_WR;
            SQ_WAIT_WR: begin
                if (wr_done) begin
                    step      = 1'b1;
                    r_d.state = SQ_IDLE;
                end
            end
            default: r_d.state = SQ_IDLE;
        endcase
        r_d.ready = (r_d.state == SQ_IDLE);
        r_d.sel   = (r_d.state != SQ_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= SQ_IDLE;
            r_q.ready <= 1'b1;
            r_q.sel   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready = r_q.ready;
    assign sel   = r_q.sel;
    assign rd    = (r_q.state == SQ_READ);
    assign wr    = (r_q.state == SQ_WRITE);

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl #(
    parameter int ADDR_W       = 4,
    parameter int NUM_WORDS    = 12,
    parameter int PERIOD_W     = 16,
    parameter int ERR_W        = 8,
    parameter bit ERR_SATURATE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic                user_busy,
    output logic                usr_ready,
    output logic                codec_sel,
    output logic [ADDR_W-1:0]   scr_addr,
    output logic                scr_rd,
    output logic                scr_wr,
    input  logic                dec_done,
    input  logic                dec_uncorr,
    input  logic                wr_done,
    output logic [ERR_W-1:0]    err_count,
    output logic [ADDR_W-1:0]   err_addr
);

    logic pending, accept, step, err_hit;

    scrub_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (cfg_period),
        .clear   (accept),
        .pending (pending)
    );

    scrub_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .user_busy  (user_busy),
        .dec_done   (dec_done),
        .dec_uncorr (dec_uncorr),
        .wr_done    (wr_done),
        .accept     (accept),
        .step       (step),
        .err_hit    (err_hit),
        .ready      (usr_ready),
        .sel        (codec_sel),
        .rd         (scr_rd),
        .wr         (scr_wr)
    );

    scrub_addr_gen #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .addr  (scr_addr)
    );

    scrub_err_log #(.ADDR_W(ADDR_W), .ERR_W(ERR_W), .SATURATE(ERR_SATURATE)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (err_hit),
        .addr_in   (scr_addr),
        .count     (err_count),
        .last_addr (err_addr)
    );

endmodule

// File: rtl/scrub_ctrl_chk.sv
module scrub_ctrl_chk #(
    parameter int ADDR_W    = 4,
    parameter int NUM_WORDS = 12,
    parameter int ERR_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              user_busy,
    input logic              usr_ready,
    input logic              codec_sel,
    input logic [ADDR_W-1:0] scr_addr,
    input logic              scr_rd,
    input logic              scr_wr,
    input logic              dec_done,
    input logic              dec_uncorr,
    input logic [ERR_W-1:0]  err_count,
    input logic [ADDR_W-1:0] err_addr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_WORDS - 1);

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        scr_rd |=> !scr_rd);                                          // R3
    AST_CMD_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_rd || scr_wr) |-> (codec_sel && !usr_ready));            // R1
    AST_SEL_OPPOSES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        codec_sel != usr_ready);                                      // R2
    AST_WR_AFTER_CLEAN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        scr_wr |-> $past(dec_done && !dec_uncorr));                   // R4
    AST_RD_NEEDS_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        scr_rd |-> $past(!user_busy));                                // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!usr_ready && $past(!usr_ready)) |-> $stable(scr_addr));     // R8
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        scr_addr <= LAST);                                            // R8
    AST_UNCORR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(usr_ready) && $past(dec_done && dec_uncorr)) |-> (err_addr == $past(scr_addr))); // R9

endmodule

bind scrub_ctrl scrub_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/sim_scrub_ctrl.sv
module sim_scrub_ctrl;

    localparam int AW = 4;
    localparam int NW = 12;
    localparam int PW = 16;
    localparam int EW = 8;
    localparam int DEC_LAT = 3;
    localparam int WR_LAT  = 2;

    typedef struct {
        logic [AW-1:0] addr;
        bit            is_wr;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] cfg_period = '0;
    logic          user_busy = 1'b0;
    logic          dec_done = 1'b0, dec_uncorr = 1'b0, wr_done = 1'b0;
    logic          usr_ready, codec_sel, scr_rd, scr_wr;
    logic [AW-1:0] scr_addr, err_addr;
    logic [EW-1:0] err_count;

    int   n_chk = 0, n_err = 0;
    int   cyc = 0;
    int   rd_seen = 0;
    int   last_rd_cyc = 0;
    bit   have_prev = 0, check_iv = 0, dec_ok = 0, finished = 0;
    int   bad_addr = 5;
    int   next_addr = 0;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scrub_ctrl #(.ADDR_W(AW), .NUM_WORDS(NW), .PERIOD_W(PW), .ERR_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .user_busy(user_busy),
        .usr_ready(usr_ready), .codec_sel(codec_sel), .scr_addr(scr_addr),
        .scr_rd(scr_rd), .scr_wr(scr_wr), .dec_done(dec_done),
        .dec_uncorr(dec_uncorr), .wr_done(wr_done),
        .err_count(err_count), .err_addr(err_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // driver: push the expected command stream for n operations
    task automatic plan_ops(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.addr = AW'(next_addr);
            e.is_wr = 0;
            q.push_back(e);
            if (next_addr != bad_addr) begin
                e.is_wr = 1;
                q.push_back(e);
            end
            next_addr = (next_addr == NW - 1) ? 0 : next_addr + 1;
        end
    endtask

    task automatic wait_drain();
        while (q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    // monitor: pops expected commands as the design issues them
    initial begin
        forever begin
            @(negedge clk);
            if (scr_rd || scr_wr) begin
                if (scr_rd) begin
                    rd_seen++;
                    check(!usr_ready && codec_sel, "R1/R2 bus held during read", usr_ready, 0);
                    if (check_iv && have_prev)
                        check(cyc - last_rd_cyc == int'(cfg_period), "R6 read spacing",
                              cyc - last_rd_cyc, int'(cfg_period));
                    have_prev = 1;
                    last_rd_cyc = cyc;
                    dec_ok = 0;
                end else begin
                    check(!usr_ready && codec_sel, "R1/R2 bus held during write", usr_ready, 0);
                    check(dec_ok, "R3 write only after decode done", dec_ok, 1);
                end
                if (q.size() == 0) begin
                    check(0, scr_rd ? "R6/R7 unexpected read" : "R4 unexpected write", scr_addr, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.is_wr == scr_wr, "R3/R4/R9 command kind", scr_wr, e.is_wr);
                    check(e.addr == scr_addr, "R8 command address", scr_addr, e.addr);
                end
            end
        end
    end

    // responder: models codec and memory completion strobes
    initial begin
        forever begin
            @(negedge clk);
            if (scr_rd) begin
                automatic int a = int'(scr_addr);
                automatic bit bad = (a == bad_addr);
                repeat (DEC_LAT) @(negedge clk);
                dec_done = 1'b1;
                dec_uncorr = bad;
                dec_ok = 1;
                check(!usr_ready, "R1 ready low while decoding", usr_ready, 0);
                @(negedge clk);
                dec_done = 1'b0;
                dec_uncorr = 1'b0;
                if (bad) begin
                    check(usr_ready && !codec_sel, "R5 ready back after uncorrectable", usr_ready, 1);
                end else begin
                    while (!scr_wr) @(negedge clk);
                    repeat (WR_LAT) @(negedge clk);
                    wr_done = 1'b1;
                    check(!usr_ready, "R1 ready low until write done", usr_ready, 0);
                    @(negedge clk);
                    wr_done = 1'b0;
                    check(usr_ready && !codec_sel, "R5 ready back after write done", usr_ready, 1);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(usr_ready == 1 && codec_sel == 0, "R10 reset ready/sel", usr_ready, 1);
        check(scr_rd == 0 && scr_wr == 0, "R10 reset commands", scr_rd | scr_wr, 0);
        check(scr_addr == 0, "R10 reset address", scr_addr, 0);
        check(err_count == 0 && err_addr == 0, "R10 reset error log", err_count, 0);
        rst_n = 1'b1;

        // phase A: steady scrubbing, wraps the address, one uncorrectable word
        plan_ops(14);
        check_iv = 1;
        cfg_period = 16'd20;
        wait_drain();
        check_iv = 0;
        check(rd_seen == 14, "R6 number of operations", rd_seen, 14);
        check(err_count == 1, "R9 error count", err_count, 1);
        check(err_addr == AW'(bad_addr), "R9 failing address", err_addr, bad_addr);

        // phase B: period 0 stops scrubbing
        cfg_period = 16'd0;
        rd_seen = 0;
        repeat (80) @(negedge clk);
        check(rd_seen == 0, "R6 period zero gives no request", rd_seen, 0);
        check(usr_ready == 1, "R6 idle with period zero", usr_ready, 1);

        // phase C: user access in flight defers the scrub
        user_busy = 1'b1;
        cfg_period = 16'd10;
        plan_ops(1);
        begin
            automatic bit ok = 1;
            repeat (40) begin
                @(negedge clk);
                if (scr_rd || !usr_ready) ok = 0;
            end
            check(ok, "R7 no read and ready high while user busy", ok, 1);
        end
        user_busy = 1'b0;
        @(negedge clk);
        check(scr_rd == 1, "R7 read right after user access ends", scr_rd, 1);
        cfg_period = 16'd0;
        wait_drain();

        // phase D: walk to the bad address once more
        plan_ops(3);
        have_prev = 0;
        check_iv = 1;
        cfg_period = 16'd15;
        wait_drain();
        check_iv = 0;
        cfg_period = 16'd0;
        repeat (30) @(negedge clk);
        check(q.size() == 0, "R8 all planned operations seen", q.size(), 0);
        check(err_count == 2, "R9 error count second hit", err_count, 2);
        check(err_addr == AW'(bad_addr), "R9 failing address second hit", err_addr, bad_addr);
        check(scr_addr == AW'(next_addr), "R8 address after skipped write", scr_addr, next_addr);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule